// File: doc/BRIEF.md
# Programmable Sum-of-Products Registered Output Slice

This block is one slice of a small programmable logic array. A shared AND plane sees every dedicated data input and every cell register, each in true and inverted form. Each output cell takes its own group of product terms from that plane and ORs them. The sum then passes through a polarity XOR and is captured by a rising-edge D flip-flop. An output select chooses what goes to the pin. A pin can show the registered value, or it can show the combinational sum while the register keeps running as buried state.

Pins are driven through an inverting three-state stage. This is modelled as a value plus an enable. The enable is active while the shared active-low output-enable input is low. The whole configuration word is static. It is copied into the slice on every clock edge with reset high, and it is held unchanged while reset is low. With the default parameters there are eight data inputs, four cells and eight terms per cell, which is enough to build a small state machine in a single slice.

Top module: `pla_slice`

## Requirements
- R1: Each clock edge with `rst` high clears all cell registers to 0. A cell in registered mode then drives `pin_val` = 1.
- R2: Array input index i runs from 0 to N_IN+N_CELL-1. Indices below N_IN are `din[i]`, and index N_IN+k is the register of cell k. Column 2i is input i true and column 2i+1 is input i inverted. A product term is the AND of all columns whose fuse bit is 1.
- R3: A term that selects both the true and the inverted column of the same input is always 0.
- R4: A term with no fuse bit set gives the value of its term-enable bit.
- R5: The cell sum is the OR of all N_TERM terms of that cell.
- R6: The flip-flop input is the sum XOR the cell polarity bit. A polarity of 0 passes the sum and a polarity of 1 inverts it.
- R7: On a rising edge with `rst` low, each cell register takes its flip-flop input.
- R8: `pin_oe` is 1 for every cell when `oe_n` is 0, and 0 when `oe_n` is 1.
- R9: Output select 1 gives `pin_val` = NOT register. Output select 0 gives `pin_val` = NOT flip-flop input in the same cycle, and the register still updates and feeds the array.
- R10: Each cell register reaches the terms of every cell through its true and inverted columns. This lets a cell use its own state or another cell's state.
- R11: Configuration layout: cell c starts at bit c*CW with CW = N_TERM*(2*(N_IN+N_CELL)+1)+2. Term t of that cell starts at offset t*TW with TW = 2*(N_IN+N_CELL)+1; its fuse bits come first and its enable bit is last. The polarity bit sits at offset N_TERM*TW and the output select at the offset after it. `cfg` is sampled only on edges with `rst` high, and changes to it while `rst` is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all cell registers |
| rst | input | 1 | Synchronous reset; clears registers and loads the configuration |
| oe_n | input | 1 | Active-low output enable shared by all pins |
| din | input | N_IN | Dedicated array inputs |
| cfg | input | CFG_W | Flat configuration word (fuses, term enables, polarity, output select) |
| pin_val | output | N_CELL | Value driven by each inverting output stage |
| pin_oe | output | N_CELL | Drive enable of each output stage |

## Verification
The assertions assume that `cfg` is stable during the reset edges that load it. The bench changes the configuration only on a falling edge and holds it through the whole reset window. The register and select checks assume a defined `din` after reset, and the bench drives every data input from time zero. A configuration change applied while running is made on a falling edge after reset, so the loaded copy is seen to stay frozen.

// File: rtl/pla_pkg.sv
package pla_pkg;
  localparam int DEF_N_IN   = 8;
  localparam int DEF_N_CELL = 4;
  localparam int DEF_N_TERM = 8;

  typedef enum logic {
    PIN_COMB = 1'b0,
    PIN_REG  = 1'b1
  } pin_src_e;
endpackage

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int N_IN   = 8,
  parameter int N_CELL = 4,
  parameter int N_TERM = 8,
  localparam int NA    = N_IN + N_CELL,
  localparam int NCOL  = 2 * NA,
  localparam int TW    = NCOL + 1,
  localparam int NT    = N_CELL * N_TERM
) (
  input  logic [N_IN-1:0]   din,
  input  logic [N_CELL-1:0] fb,
  input  logic [NT*TW-1:0]  term_cfg,
  output logic [NT-1:0]     term_hit
);
  logic [NA-1:0]   arr_in;
  logic [NCOL-1:0] cols;

  assign arr_in = {fb, din};

  // Empty term falls back to its enable; otherwise AND of selected columns.
  function automatic logic eval_term(input logic [NCOL-1:0] fz,
                                     input logic en,
                                     input logic [NCOL-1:0] col);
    if (fz == '0) return en;
    return &(col | ~fz);
  endfunction

  for (genvar i = 0; i < NA; i++) begin : g_col
    assign cols[2*i]   = arr_in[i];
    assign cols[2*i+1] = ~arr_in[i];
  end

  for (genvar t = 0; t < NT; t++) begin : g_term
    logic [NCOL-1:0] fz;
    logic            en;
    assign fz          = term_cfg[t*TW +: NCOL];
    assign en          = term_cfg[t*TW + NCOL];
    assign term_hit[t] = eval_term(fz, en, cols);
  end
endmodule

// File: rtl/pla_out_cell.sv
module pla_out_cell #(
  parameter int N_TERM = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              oe_n,
  input  logic [N_TERM-1:0] terms,
  input  logic              pol,
  input  pla_pkg::pin_src_e src,
  output logic              q,
  output logic              d,
  output logic              pin_val,
  output logic              pin_oe
);
  logic sum;

  assign sum = |terms;
  assign d   = sum ^ pol;

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d;
  end

  assign pin_val = (src == pla_pkg::PIN_REG) ? ~q : ~d;
  assign pin_oe  = ~oe_n;
endmodule

// File: rtl/pla_slice.sv
module pla_slice #(
  parameter int N_IN   = pla_pkg::DEF_N_IN,
  parameter int N_CELL = pla_pkg::DEF_N_CELL,
  parameter int N_TERM = pla_pkg::DEF_N_TERM,
  localparam int NA    = N_IN + N_CELL,
  localparam int TW    = 2 * NA + 1,
  localparam int CW    = N_TERM * TW + 2,
  localparam int CFG_W = N_CELL * CW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              oe_n,
  input  logic [N_IN-1:0]   din,
  input  logic [CFG_W-1:0]  cfg,
  output logic [N_CELL-1:0] pin_val,
  output logic [N_CELL-1:0] pin_oe
);
  logic [CFG_W-1:0]         cfg_q;
  logic [N_CELL*N_TERM*TW-1:0] term_cfg;
  logic [N_CELL*N_TERM-1:0] term_hit;
  logic [N_CELL-1:0]        cell_q;
  logic [N_CELL-1:0]        cell_d;
  logic [N_CELL-1:0]        cell_reg;

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= cfg;
  end

  pla_and_plane #(.N_IN(N_IN), .N_CELL(N_CELL), .N_TERM(N_TERM)) u_plane (
    .din      (din),
    .fb       (cell_q),
    .term_cfg (term_cfg),
    .term_hit (term_hit)
  );

  for (genvar c = 0; c < N_CELL; c++) begin : g_cell
    pla_pkg::pin_src_e src;
    assign term_cfg[c*N_TERM*TW +: N_TERM*TW] = cfg_q[c*CW +: N_TERM*TW];
    assign src         = pla_pkg::pin_src_e'(cfg_q[c*CW + N_TERM*TW + 1]);
    assign cell_reg[c] = cfg_q[c*CW + N_TERM*TW + 1];

    pla_out_cell #(.N_TERM(N_TERM)) u_cell (
      .clk     (clk),
      .rst     (rst),
      .oe_n    (oe_n),
      .terms   (term_hit[c*N_TERM +: N_TERM]),
      .pol     (cfg_q[c*CW + N_TERM*TW]),
      .src     (src),
      .q       (cell_q[c]),
      .d       (cell_d[c]),
      .pin_val (pin_val[c]),
      .pin_oe  (pin_oe[c])
    );
  end
endmodule

// File: rtl/pla_slice_chk.sv
module pla_slice_chk #(
  parameter int N_CELL = 4,
  parameter int CFG_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              oe_n,
  input logic [N_CELL-1:0] pin_val,
  input logic [N_CELL-1:0] pin_oe,
  input logic [N_CELL-1:0] cell_q,
  input logic [N_CELL-1:0] cell_d,
  input logic [N_CELL-1:0] cell_reg,
  input logic [CFG_W-1:0]  cfg_q
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> cell_q == '0);

  // R7
  reg_capture_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cell_q == $past(cell_d));

  // R8
  out_enable_chk: assert property (@(posedge clk) disable iff (rst)
    pin_oe == {N_CELL{~oe_n}});

  // R9
  pin_select_chk: assert property (@(posedge clk) disable iff (rst)
    pin_val == ~((cell_reg & cell_q) | (~cell_reg & cell_d)));

  // R11
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(cfg_q));
endmodule

bind pla_slice pla_slice_chk #(.N_CELL(N_CELL), .CFG_W(CFG_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .oe_n     (oe_n),
  .pin_val  (pin_val),
  .pin_oe   (pin_oe),
  .cell_q   (cell_q),
  .cell_d   (cell_d),
  .cell_reg (cell_reg),
  .cfg_q    (cfg_q)
);

// File: tb/sim_pla_slice.sv
module sim_pla_slice;
  localparam int PERIOD = 10;
  localparam int NI = 8, NC = 4, NTM = 8;
  localparam int NA = NI + NC, NCOL = 2 * NA, TW = NCOL + 1;
  localparam int CW = NTM * TW + 2, CFG_W = NC * CW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic oe_n = 1'b1;
  logic [NI-1:0] din = '0;
  logic [CFG_W-1:0] cfg = '0;
  logic [NC-1:0] pin_val, pin_oe;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct { logic [NC-1:0] v; logic [NC-1:0] oe; string tag; } exp_t;
  exp_t sbq[$];

  logic [CFG_W-1:0] mcfg = '0;
  logic [NC-1:0]    mq = '0;

  always #(PERIOD/2) clk = ~clk;

  pla_slice u0 (.clk(clk), .rst(rst), .oe_n(oe_n), .din(din), .cfg(cfg),
                .pin_val(pin_val), .pin_oe(pin_oe));

  // configuration helpers (bench's own view of the layout)
  task automatic fuse(input int c, input int t, input int col);
    cfg[c*CW + t*TW + col] = 1'b1;
  endtask
  task automatic ten(input int c, input int t, input logic v);
    cfg[c*CW + t*TW + NCOL] = v;
  endtask
  task automatic pol(input int c, input logic v);
    cfg[c*CW + NTM*TW] = v;
  endtask
  task automatic osel(input int c, input logic v);
    cfg[c*CW + NTM*TW + 1] = v;
  endtask

  function automatic logic m_d(input int c, input logic [NI-1:0] x, input logic [NC-1:0] qv);
    logic [NA-1:0] inp;
    logic s;
    inp = {qv, x};
    s = 1'b0;
    for (int t = 0; t < NTM; t++) begin
      logic any, p;
      any = 1'b0; p = 1'b1;
      for (int k = 0; k < NCOL; k++) begin
        if (mcfg[c*CW + t*TW + k]) begin
          any = 1'b1;
          if (k % 2 == 0) p = p & inp[k/2];
          else            p = p & ~inp[k/2];
        end
      end
      if (!any) p = mcfg[c*CW + t*TW + NCOL];
      s = s | p;
    end
    return s ^ mcfg[c*CW + NTM*TW];
  endfunction

  task automatic step(input logic r, input logic [NI-1:0] x, input logic oen, input string tag);
    exp_t e;
    logic [NC-1:0] nq;
    @(negedge clk);
    rst = r; din = x; oe_n = oen;
    if (r) begin mcfg = cfg; nq = '0; end
    else for (int c = 0; c < NC; c++) nq[c] = m_d(c, x, mq);
    mq = nq;
    for (int c = 0; c < NC; c++)
      e.v[c] = mcfg[c*CW + NTM*TW + 1] ? ~mq[c] : ~m_d(c, x, mq);
    e.oe = {NC{~oen}};
    e.tag = tag;
    sbq.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #(PERIOD/4);
      if (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        checks++;
        if (pin_val !== e.v || pin_oe !== e.oe) begin
          errors++;
          $display("FAIL %s: pin_val=%b pin_oe=%b expected pin_val=%b pin_oe=%b",
                   e.tag, pin_val, pin_oe, e.v, e.oe);
        end
      end
    end
  end

  initial begin : watchdog
    #(PERIOD * 5000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    // Set A
    cfg = '0;
    fuse(0, 0, 0); fuse(0, 0, 3);          // R2: din0 & ~din1
    fuse(0, 1, 4);                          // R5: OR din2
    osel(0, 1'b1);
    fuse(1, 0, 6); fuse(1, 0, 7);           // R3: din3 & ~din3
    fuse(1, 1, 2*(NI+0));                   // R10: cell0 register true
    osel(1, 1'b0);
    ten(2, 0, 1'b1); pol(2, 1'b1); osel(2, 1'b1); // R4, R6
    fuse(3, 0, 2*(NI+3)+1); osel(3, 1'b1);  // R10: own register inverted -> toggle
    step(1'b1, 8'h00, 1'b1, "R1 reset");
    step(1'b1, 8'h01, 1'b0, "R1 R8 reset");
    step(1'b0, 8'h01, 1'b0, "R2 R7 R10");
    step(1'b0, 8'h03, 1'b0, "R2 R3 R9");
    step(1'b0, 8'h04, 1'b1, "R5 R8 R10");
    step(1'b0, 8'h08, 1'b0, "R3 R4 R6");
    step(1'b0, 8'hFF, 1'b0, "R3 R5 R9");
    step(1'b0, 8'h00, 1'b0, "R7 R10");
    // R11: change cfg while running; must have no effect
    cfg = '0; pol(0, 1'b1); pol(1, 1'b1); osel(3, 1'b0);
    step(1'b0, 8'h01, 1'b0, "R11 ignored");
    step(1'b0, 8'h05, 1'b1, "R11 ignored");
    // Set B: all eight terms of cell 0, polarity mix, combinational pins
    cfg = '0;
    for (int t = 0; t < NTM; t++) fuse(0, t, 2*t);
    osel(0, 1'b0);
    for (int t = 0; t < NTM; t++) fuse(1, t, 2*t);
    pol(1, 1'b1); osel(1, 1'b1);
    ten(2, 3, 1'b0); osel(2, 1'b0);         // R4: empty and disabled -> 0
    fuse(3, 0, 2*(NI+1)); pol(3, 1'b0); osel(3, 1'b0); // buried use of cell1
    step(1'b1, 8'h00, 1'b0, "R1 R11 reload");
    step(1'b0, 8'h00, 1'b0, "R5 R6 R4");
    step(1'b0, 8'h80, 1'b0, "R5 R6 R9");
    step(1'b0, 8'h10, 1'b0, "R5 R10 R9");
    step(1'b0, 8'h00, 1'b0, "R7 R9 R10");
    step(1'b0, 8'h00, 1'b1, "R8 R9");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule